// File: doc/BRIEF.md
# Static Two-Wide Pair Fetch and Issue Front End

This block sits at the front of an in-order pipeline that issues two instructions per cycle under a schedule fixed by the compiler. Each cycle it fetches one 64-bit word from instruction memory at an 8-byte-aligned program counter. That word holds two 32-bit instructions. The lower word (byte offset 0) is the compute slot and may hold only an ALU operation, a branch or a jump. The upper word (byte offset 4) is the memory slot and may hold only a load or a store. Either slot may hold a NOP.

The block decodes both slots in the cycle the pair arrives. It steers four register-file read addresses and gets the read data back in the same cycle. It produces the two write enables and their destination addresses. It forms the load/store address with an adder of its own. It resolves an equal-compare branch or a jump and advances the program counter. The schedule guarantees that the two slots are independent, so the block makes no dependence check. A pair whose slots hold the wrong instruction classes is not reordered. It is flagged and made harmless.

Top module: `pair_issue_front`

## Requirements
- R1: While `rst_n` is low, `imem_addr` is 0, and it goes to 0 as soon as `rst_n` falls, without waiting for a clock edge. After `rst_n` rises, the address stays 0 through two more rising edges and first advances on the third. `imem_addr[2:0]` is always 0.
- R2: When `br_redirect` is low in a cycle, `imem_addr` rises by 8 at the next rising edge. This includes cycles that carry an illegal pair.
- R3: Field layout. The compute slot is `imem_pair[31:0]` and the memory slot is `imem_pair[63:32]`. In each slot, bits [31:26] are the opcode, [25:21] the first source, [20:16] the second source or target, [15:11] the destination of a register-form ALU op, [15:0] a 16-bit immediate and [25:0] a jump index. Read ports 0 and 1 always carry the compute slot's bits [25:21] and [20:16]. Read ports 2 and 3 always carry the memory slot's bits [25:21] and [20:16].
- R4: Opcodes are 0 NOP, 1 register ALU, 2 immediate ALU, 3 branch-if-equal, 4 jump, 8 load and 9 store. The compute slot accepts only 0 to 4. The memory slot accepts only 0, 8 and 9. Any other value in a slot sets `illegal_pair`, and in that cycle `wen_a`, `wen_b`, `mem_rd_en`, `mem_wr_en` and `br_redirect` are all 0.
- R5: In a legal pair, a register ALU op writes its bits [15:11] on port A. An immediate ALU op writes its bits [20:16] on port A. A load writes its bits [20:16] on port B. Stores, branches, jumps and NOPs write nothing.
- R6: In a legal pair, a load raises `mem_rd_en` and a store raises `mem_wr_en`. `mem_addr` is the read-port-2 data plus the sign-extended immediate. `mem_wdata` is the read-port-3 data. The two strobes are never high together.
- R7: If both slots would write the same register in one cycle, only `wen_b` is raised.
- R8: A legal branch-if-equal is taken when the read-port-0 data equals the read-port-1 data. In that case `br_redirect` is 1 and the next address is (current address + sign-extended immediate × 4) with bits [2:0] cleared. The memory-slot instruction of the same pair still issues.
- R9: A legal jump always raises `br_redirect`. The next address is the current address bits [31:28], then the 26-bit index, then two zero bits, with bits [2:0] then cleared.
- R10: A NOP is legal in either slot, writes nothing, makes no memory access and does not redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Fetch address (program counter) |
| imem_pair | input | 64 | Fetched instruction pair, same cycle |
| rf_ra0 | output | 5 | Read address, compute slot first source |
| rf_ra1 | output | 5 | Read address, compute slot second source |
| rf_ra2 | output | 5 | Read address, memory slot base |
| rf_ra3 | output | 5 | Read address, memory slot store data |
| rf_rd0 | input | 32 | Read data for port 0 |
| rf_rd1 | input | 32 | Read data for port 1 |
| rf_rd2 | input | 32 | Read data for port 2 |
| rf_rd3 | input | 32 | Read data for port 3 |
| wen_a | output | 1 | Write enable, compute slot |
| wadr_a | output | 5 | Write address, compute slot |
| wen_b | output | 1 | Write enable, memory slot |
| wadr_b | output | 5 | Write address, memory slot |
| mem_rd_en | output | 1 | Load strobe |
| mem_wr_en | output | 1 | Store strobe |
| mem_addr | output | 32 | Load/store address |
| mem_wdata | output | 32 | Store data |
| br_redirect | output | 1 | Next fetch follows a taken branch or jump |
| illegal_pair | output | 1 | Slot-class violation in the current pair |

## Verification
Some properties can be checked every cycle, and the assertions cover those. An illegal pair must stay quiet. The address must step by 8 when there is no redirect. The fetch address must stay aligned. Two write enables never share a destination, and the two memory strobes are never raised together. Other behaviour depends on particular encodings and operand values, so only the bench's scenarios can show it. That includes the exact destination chosen per opcode, the load/store address arithmetic, branch targets with bits cleared for positive and negative offsets, and a compare that fails. It also includes the two-edge hold after reset release and the asynchronous entry into reset.

// File: rtl/pair_issue_pkg.sv
package pair_issue_pkg;
  localparam int XLEN  = 32;
  localparam int ILEN  = 32;
  localparam int NSLOT = 2;
  localparam int RAW   = 5;
  localparam int OPW   = 6;
  localparam int IMMW  = 16;
  localparam int JIW   = 26;
  localparam int ALIGN = 3;

  localparam logic [OPW-1:0] OP_NOP  = 6'd0;
  localparam logic [OPW-1:0] OP_ALUR = 6'd1;
  localparam logic [OPW-1:0] OP_ALUI = 6'd2;
  localparam logic [OPW-1:0] OP_BEQ  = 6'd3;
  localparam logic [OPW-1:0] OP_JMP  = 6'd4;
  localparam logic [OPW-1:0] OP_LD   = 6'd8;
  localparam logic [OPW-1:0] OP_ST   = 6'd9;

  typedef enum logic [2:0] {
    CL_NOP, CL_ALUR, CL_ALUI, CL_BEQ, CL_JMP, CL_LD, CL_ST, CL_BAD
  } slot_cls_t;

  typedef enum logic [1:0] {
    DST_NONE, DST_RD, DST_RT
  } dst_sel_t;
endpackage

// File: rtl/pair_slot_decode.sv
module pair_slot_decode
  import pair_issue_pkg::*;
#(
  parameter bit MEM_SLOT = 1'b0
) (
  input  logic [OPW-1:0] op,
  output slot_cls_t      cls,
  output logic           legal,
  output dst_sel_t       dst
);
  slot_cls_t raw_cls;

  always_comb begin
    unique case (op)
      OP_NOP:  raw_cls = CL_NOP;
      OP_ALUR: raw_cls = CL_ALUR;
      OP_ALUI: raw_cls = CL_ALUI;
      OP_BEQ:  raw_cls = CL_BEQ;
      OP_JMP:  raw_cls = CL_JMP;
      OP_LD:   raw_cls = CL_LD;
      OP_ST:   raw_cls = CL_ST;
      default: raw_cls = CL_BAD;
    endcase
  end

  generate
    if (MEM_SLOT) begin : g_mem
      always_comb begin
        legal = (raw_cls == CL_NOP) || (raw_cls == CL_LD) || (raw_cls == CL_ST);
        cls   = legal ? raw_cls : CL_BAD;
        dst   = (cls == CL_LD) ? DST_RT : DST_NONE;
      end
    end else begin : g_cmp
      always_comb begin
        legal = (raw_cls == CL_NOP) || (raw_cls == CL_ALUR) || (raw_cls == CL_ALUI) ||
                (raw_cls == CL_BEQ) || (raw_cls == CL_JMP);
        cls   = legal ? raw_cls : CL_BAD;
        case (cls)
          CL_ALUR: dst = DST_RD;
          CL_ALUI: dst = DST_RT;
          default: dst = DST_NONE;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/pair_agu.sv
module pair_agu
  import pair_issue_pkg::*;
(
  input  logic [XLEN-1:0] base,
  input  logic [IMMW-1:0] ofs,
  output logic [XLEN-1:0] addr
);
  localparam int EXT = XLEN - IMMW;
  always_comb addr = base + {{EXT{ofs[IMMW-1]}}, ofs};
endmodule

// File: rtl/pair_pc_unit.sv
module pair_pc_unit
  import pair_issue_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_sync_n,
  input  logic            pc_en,
  input  logic            redirect,
  input  logic [XLEN-1:0] target,
  output logic [XLEN-1:0] pc
);
  localparam logic [XLEN-1:0] STEP = XLEN'(1) << ALIGN;

  logic [XLEN-1:0] pc_q, pc_d;

  always_comb begin
    pc_d = pc_q;
    if (pc_en) pc_d = redirect ? target : (pc_q + STEP);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pc_q <= RESET_PC;
    else             pc_q <= pc_d;
  end

  assign pc = pc_q;
endmodule

// File: rtl/pair_issue_front.sv
module pair_issue_front
  import pair_issue_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [XLEN-1:0]      imem_addr,
  input  logic [NSLOT*ILEN-1:0] imem_pair,
  output logic [RAW-1:0]       rf_ra0,
  output logic [RAW-1:0]       rf_ra1,
  output logic [RAW-1:0]       rf_ra2,
  output logic [RAW-1:0]       rf_ra3,
  input  logic [XLEN-1:0]      rf_rd0,
  input  logic [XLEN-1:0]      rf_rd1,
  input  logic [XLEN-1:0]      rf_rd2,
  input  logic [XLEN-1:0]      rf_rd3,
  output logic                 wen_a,
  output logic [RAW-1:0]       wadr_a,
  output logic                 wen_b,
  output logic [RAW-1:0]       wadr_b,
  output logic                 mem_rd_en,
  output logic                 mem_wr_en,
  output logic [XLEN-1:0]      mem_addr,
  output logic [XLEN-1:0]      mem_wdata,
  output logic                 br_redirect,
  output logic                 illegal_pair
);
  localparam int SYNC_STAGES = 2;
  localparam int IMM_EXT     = XLEN - IMMW - 2;
  localparam int PC_HI       = XLEN - JIW - 2;

  // reset: asserted asynchronously, released after SYNC_STAGES edges
  logic [SYNC_STAGES-1:0] rsync_q, rsync_d;
  logic rst_sync_n;

  always_comb rsync_d = {rsync_q[SYNC_STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= rsync_d;
  end

  assign rst_sync_n = rsync_q[SYNC_STAGES-1];

  // per-slot field extraction and class decode
  logic [ILEN-1:0]  word  [NSLOT];
  logic [RAW-1:0]   f_rs  [NSLOT];
  logic [RAW-1:0]   f_rt  [NSLOT];
  logic [RAW-1:0]   f_rd  [NSLOT];
  slot_cls_t        cls   [NSLOT];
  logic             legal [NSLOT];
  dst_sel_t         dsel  [NSLOT];
  logic             wr_req[NSLOT];
  logic [RAW-1:0]   wr_adr[NSLOT];

  generate
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign word[s] = imem_pair[s*ILEN +: ILEN];
      assign f_rs[s] = word[s][25:21];
      assign f_rt[s] = word[s][20:16];
      assign f_rd[s] = word[s][15:11];

      pair_slot_decode #(.MEM_SLOT(s == 1)) u_dec (
        .op    (word[s][31:26]),
        .cls   (cls[s]),
        .legal (legal[s]),
        .dst   (dsel[s])
      );

      always_comb begin
        wr_req[s] = (dsel[s] != DST_NONE);
        wr_adr[s] = (dsel[s] == DST_RD) ? f_rd[s] : f_rt[s];
      end
    end
  endgenerate

  // register-file read steering: slot 0 -> ports 0/1, slot 1 -> ports 2/3
  assign rf_ra0 = f_rs[0];
  assign rf_ra1 = f_rt[0];
  assign rf_ra2 = f_rs[1];
  assign rf_ra3 = f_rt[1];

  // pair legality and write-port control
  logic pair_ok, collide;

  always_comb begin
    pair_ok      = legal[0] && legal[1];
    illegal_pair = !pair_ok;
    collide      = wr_req[0] && wr_req[1] && (wr_adr[0] == wr_adr[1]);
    wen_b        = pair_ok && wr_req[1];
    wen_a        = pair_ok && wr_req[0] && !collide;
    wadr_a       = wr_adr[0];
    wadr_b       = wr_adr[1];
  end

  // memory slot
  pair_agu u_agu (
    .base (rf_rd2),
    .ofs  (word[1][IMMW-1:0]),
    .addr (mem_addr)
  );

  always_comb begin
    mem_rd_en = pair_ok && (cls[1] == CL_LD);
    mem_wr_en = pair_ok && (cls[1] == CL_ST);
    mem_wdata = rf_rd3;
  end

  // branch resolution in the compute slot
  logic [XLEN-1:0] pc, beq_tgt, jmp_tgt, raw_tgt, target;
  logic            beq_hit;

  always_comb begin
    beq_hit     = (rf_rd0 == rf_rd1);
    beq_tgt     = pc + {{IMM_EXT{word[0][IMMW-1]}}, word[0][IMMW-1:0], 2'b00};
    jmp_tgt     = {pc[XLEN-1 -: PC_HI], word[0][JIW-1:0], 2'b00};
    raw_tgt     = (cls[0] == CL_JMP) ? jmp_tgt : beq_tgt;
    target      = {raw_tgt[XLEN-1:ALIGN], {ALIGN{1'b0}}};
    br_redirect = pair_ok && ((cls[0] == CL_JMP) || ((cls[0] == CL_BEQ) && beq_hit));
  end

  pair_pc_unit #(.RESET_PC(RESET_PC)) u_pc (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .pc_en      (rst_sync_n),
    .redirect   (br_redirect),
    .target     (target),
    .pc         (pc)
  );

  assign imem_addr = pc;
endmodule

// File: rtl/pair_issue_front_chk.sv
module pair_issue_front_chk (
  input logic        clk,
  input logic        rst_sync_n,
  input logic [31:0] imem_addr,
  input logic        wen_a,
  input logic [4:0]  wadr_a,
  input logic        wen_b,
  input logic [4:0]  wadr_b,
  input logic        mem_rd_en,
  input logic        mem_wr_en,
  input logic        br_redirect,
  input logic        illegal_pair
);
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    illegal_pair |-> !(wen_a || wen_b || mem_rd_en || mem_wr_en || br_redirect)); // R4

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !br_redirect |=> (imem_addr == $past(imem_addr) + 32'd8)); // R2

  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    imem_addr[2:0] == 3'b000); // R1

  AST_REDIRECT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    br_redirect |=> (imem_addr[2:0] == 3'b000)); // R8

  AST_DEST_UNIQUE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wen_a && wen_b) |-> (wadr_a != wadr_b)); // R7

  AST_MEM_STROBES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({mem_rd_en, mem_wr_en})); // R6
endmodule

bind pair_issue_front pair_issue_front_chk u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .imem_addr    (imem_addr),
  .wen_a        (wen_a),
  .wadr_a       (wadr_a),
  .wen_b        (wen_b),
  .wadr_b       (wadr_b),
  .mem_rd_en    (mem_rd_en),
  .mem_wr_en    (mem_wr_en),
  .br_redirect  (br_redirect),
  .illegal_pair (illegal_pair)
);

// File: tb/pair_issue_front_test.sv
module pair_issue_front_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] imem_addr;
  logic [63:0] imem_pair;
  logic [4:0]  rf_ra0, rf_ra1, rf_ra2, rf_ra3;
  logic [31:0] rf_rd0, rf_rd1, rf_rd2, rf_rd3;
  logic        wen_a, wen_b, mem_rd_en, mem_wr_en, br_redirect, illegal_pair;
  logic [4:0]  wadr_a, wadr_b;
  logic [31:0] mem_addr, mem_wdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pair_issue_front uut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_pair(imem_pair),
    .rf_ra0(rf_ra0), .rf_ra1(rf_ra1), .rf_ra2(rf_ra2), .rf_ra3(rf_ra3),
    .rf_rd0(rf_rd0), .rf_rd1(rf_rd1), .rf_rd2(rf_rd2), .rf_rd3(rf_rd3),
    .wen_a(wen_a), .wadr_a(wadr_a), .wen_b(wen_b), .wadr_b(wadr_b),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .br_redirect(br_redirect), .illegal_pair(illegal_pair)
  );

  // register-file model: register r holds 0x1000 + 16*r
  function automatic logic [31:0] rfv(input logic [4:0] r);
    return 32'h1000 + ({27'd0, r} << 4);
  endfunction

  always_comb begin
    rf_rd0 = rfv(rf_ra0);
    rf_rd1 = rfv(rf_ra1);
    rf_rd2 = rfv(rf_ra2);
    rf_rd3 = rfv(rf_ra3);
  end

  // instruction encoders (layout from R3/R4)
  function automatic logic [31:0] iR(input logic [4:0] rd, rs, rt);
    return {6'd1, rs, rt, rd, 11'd0};
  endfunction
  function automatic logic [31:0] iI(input logic [4:0] rt, rs, input logic [15:0] imm);
    return {6'd2, rs, rt, imm};
  endfunction
  function automatic logic [31:0] iBEQ(input logic [4:0] rs, rt, input logic [15:0] imm);
    return {6'd3, rs, rt, imm};
  endfunction
  function automatic logic [31:0] iJ(input logic [25:0] idx);
    return {6'd4, idx};
  endfunction
  function automatic logic [31:0] iLD(input logic [4:0] rt, rs, input logic [15:0] imm);
    return {6'd8, rs, rt, imm};
  endfunction
  function automatic logic [31:0] iST(input logic [4:0] rt, rs, input logic [15:0] imm);
    return {6'd9, rs, rt, imm};
  endfunction

  typedef struct packed {
    logic [63:0] pair;
    logic        wa;
    logic [4:0]  aa;
    logic        wb;
    logic [4:0]  ab;
    logic        ill;
    logic        mrd;
    logic        mwr;
    logic [31:0] maddr;
    logic        redir;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{ {32'd0, 32'd0},                               1'b0, 5'd0,  1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 32'h0, 1'b0 },
    '{ {iLD(5'd4, 5'd5, 16'd8), iR(5'd3, 5'd1, 5'd2)}, 1'b1, 5'd3,  1'b1, 5'd4,  1'b0, 1'b1, 1'b0, 32'h1058, 1'b0 },
    '{ {iST(5'd6, 5'd9, 16'hFFF0), iI(5'd7, 5'd2, 16'hFFFF)}, 1'b1, 5'd7, 1'b0, 5'd6, 1'b0, 1'b0, 1'b1, 32'h1080, 1'b0 },
    '{ {iLD(5'd10, 5'd3, 16'd0), iR(5'd10, 5'd1, 5'd2)}, 1'b0, 5'd10, 1'b1, 5'd10, 1'b0, 1'b1, 1'b0, 32'h1030, 1'b0 },
    '{ {32'd0, iLD(5'd4, 5'd5, 16'd8)},              1'b0, 5'd0,  1'b0, 5'd0,  1'b1, 1'b0, 1'b0, 32'h0, 1'b0 },
    '{ {iR(5'd8, 5'd1, 5'd2), iR(5'd3, 5'd1, 5'd2)}, 1'b0, 5'd3,  1'b0, 5'd0,  1'b1, 1'b0, 1'b0, 32'h0, 1'b0 },
    '{ {32'hFC00_0000, iI(5'd7, 5'd2, 16'd1)},       1'b0, 5'd7,  1'b0, 5'd0,  1'b1, 1'b0, 1'b0, 32'h0, 1'b0 },
    '{ {iLD(5'd2, 5'd1, 16'd4), iBEQ(5'd4, 5'd4, 16'd5)}, 1'b0, 5'd0, 1'b1, 5'd2, 1'b0, 1'b1, 1'b0, 32'h1014, 1'b1 },
    '{ {32'd0, iBEQ(5'd4, 5'd5, 16'd5)},             1'b0, 5'd0,  1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 32'h0, 1'b0 },
    '{ {iST(5'd1, 5'd2, 16'd0), iJ(26'h123)},        1'b0, 5'd0,  1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 32'h1020, 1'b1 },
    '{ {iR(5'd8, 5'd1, 5'd2), iJ(26'h55)},           1'b0, 5'd0,  1'b0, 5'd0,  1'b1, 1'b0, 1'b0, 32'h0, 1'b0 },
    '{ {32'd0, iBEQ(5'd7, 5'd7, 16'hFFFD)},          1'b0, 5'd0,  1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 32'h0, 1'b1 },
    '{ {iLD(5'd9, 5'd0, 16'h8000), 32'd0},           1'b0, 5'd0,  1'b1, 5'd9,  1'b0, 1'b1, 1'b0, 32'hFFFF_9000, 1'b0 }
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // next-address rule from R8/R9
  function automatic logic [31:0] next_tgt(input logic [31:0] pc, input logic [31:0] a);
    logic [31:0] t;
    if (a[31:26] == 6'd4) t = {pc[31:28], a[25:0], 2'b00};
    else                  t = pc + ({{16{a[15]}}, a[15:0]} << 2);
    return {t[31:3], 3'b000};
  endfunction

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] pc_now, exp_pc;
    bit have_exp;
    rst_n = 1'b0;
    imem_pair = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset address", imem_addr, 32'h0);

    // release: held for two edges, steps on the third
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 hold after release edge 1", imem_addr, 32'h0);
    @(negedge clk);
    chk("R1 hold after release edge 2", imem_addr, 32'h0);
    @(negedge clk);
    chk("R1 first step", imem_addr, 32'h8);

    // vector walk
    have_exp = 1'b0;
    exp_pc = '0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (have_exp) chk("R2/R8/R9 next address", imem_addr, exp_pc);
      imem_pair = VEC[i].pair;
      #1;
      chk("R3 read port 0", rf_ra0, VEC[i].pair[25:21]);
      chk("R3 read port 1", rf_ra1, VEC[i].pair[20:16]);
      chk("R3 read port 2", rf_ra2, VEC[i].pair[57:53]);
      chk("R3 read port 3", rf_ra3, VEC[i].pair[52:48]);
      chk("R4 illegal flag", illegal_pair, VEC[i].ill);
      chk("R5/R7/R10 wen_a", wen_a, VEC[i].wa);
      chk("R5/R7/R10 wen_b", wen_b, VEC[i].wb);
      if (VEC[i].wa) chk("R5 wadr_a", wadr_a, VEC[i].aa);
      if (VEC[i].wb) chk("R5 wadr_b", wadr_b, VEC[i].ab);
      chk("R6 load strobe", mem_rd_en, VEC[i].mrd);
      chk("R6 store strobe", mem_wr_en, VEC[i].mwr);
      if (VEC[i].mrd || VEC[i].mwr) chk("R6 address", mem_addr, VEC[i].maddr);
      if (VEC[i].mwr) chk("R6 store data", mem_wdata, rfv(VEC[i].pair[52:48]));
      chk("R8/R9 redirect", br_redirect, VEC[i].redir);
      pc_now = imem_addr;
      exp_pc = VEC[i].redir ? next_tgt(pc_now, VEC[i].pair[31:0]) : pc_now + 32'd8;
      have_exp = 1'b1;
    end
    @(negedge clk);
    chk("R2 final step", imem_addr, exp_pc);
    chk("R1 alignment", imem_addr[2:0], 3'b000);

    // asynchronous reset entry between edges
    imem_pair = '0;
    #2;
    rst_n = 1'b0;
    #1;
    chk("R1 async reset", imem_addr, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 restart step", imem_addr, 32'h8);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule